// File: doc/BRIEF.md
# I2C Bus Hang Recovery Sequencer

This block frees a stuck I2C bus from the controller side. A target that was reset partway through a byte can keep SDA low indefinitely, and ordinary transfers are then impossible. When the sequencer is started it leaves SDA undriven. It then toggles SCL on its own, one full clock pulse at a time, and after each pulse it checks whether the target has let go of SDA. As soon as SDA reads high it stops clocking and closes with a STOP condition. If SDA is still low after the last allowed pulse, it gives up and raises a fault, so that the system can move to its safe state.

Both bus lines are open-drain. The block only ever asserts a "pull low" enable per line and reads each line back through a two-flop synchronizer. The SCL half-period comes from a programmable divider. SDA is sampled in the middle of every SCL high phase. A target that stretches SCL low for longer than a programmable limit aborts the sequence with a fault. Each sequence ends with a one-cycle completion pulse, and a success or fault level that stays valid until the next start.

Top module: `bus_unstick`

## Requirements
- R1: Out of reset, both drive-low outputs are 0 and done, success and fault are all 0.
- R2: SDA is not pulled low from the start strobe until the STOP phase begins. Whenever SCL starts being pulled low, SDA is released in that cycle.
- R3: Every interval in which SCL is pulled low lasts exactly Heff clock cycles, where Heff = halfPeriod, or 4 when halfPeriod is below 4.
- R4: At least one SCL pulse is always issued. SDA is sampled in the middle of each SCL high phase. The number of pulses issued is the number of the first pulse at which SDA was seen high.
- R5: After a pulse that saw SDA high, the block runs a STOP. It pulls SCL low, then pulls SDA low while SCL is low, then releases SCL, and finally releases SDA while SCL is high. It then reports success. SDA is never pulled low while the SCL line is high.
- R6: If SDA is still low after the ninth pulse (MAX_PULSES = 9), the block reports fault, releases both lines, and generates no STOP.
- R7: After SCL is released, if the SCL line stays low for at least stretchLimit cycles, the block aborts with fault. A hold of stretchLimit−3 cycles or less does not cause a fault.
- R8: done is high for exactly one cycle per sequence. In that cycle exactly one of success and fault is 1, and that value holds until the next start.
- R9: A start strobe that arrives while a sequence is running is ignored. The running sequence ends unchanged, with a single done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle strobe that begins a recovery sequence |
| halfPeriod | input | DIV_W | SCL half-period in clock cycles (minimum 4 applied) |
| stretchLimit | input | STRETCH_W | Cycles SCL may stay low after release before an abort |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Sequence ended with a STOP after SDA was released |
| fault | output | 1 | Sequence ended without release, or on a clock-stretch timeout |

## Verification
A wrong pulse count or a stuck divider shows up at the pins within one SCL period. A low phase of the wrong length is visible on the first SCL pulse, and a missed SDA sample appears as extra rising SCL edges before the STOP. A control state that drives SDA at the wrong moment produces a false START or a STOP with SCL low, which can be seen in the same cycle. The bench sweeps the release pulse from zero to beyond the limit against several half-periods. It compares edge counts, low-phase widths and the closing result with values it computes arithmetically.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_HIGH,
    ST_STOP_LOW,
    ST_STOP_WAIT,
    ST_STOP_HIGH
  } seqState_t;

  typedef struct packed {
    logic clearCnt;
    logic pulseInc;
    logic pulseClear;
    logic sampleEn;
    logic resultClear;
    logic finishOk;
    logic finishFault;
  } ctrlStrobe_t;

endpackage

// File: rtl/unstick_datapath.sv
module unstick_datapath
  import unstick_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int STRETCH_W   = 8,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HALF    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [DIV_W-1:0]     halfPeriod,
  input  logic [STRETCH_W-1:0] stretchLimit,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 phaseEnd,
  output logic                 pastMid,
  output logic                 sclSeen,
  output logic                 stretchOver,
  output logic                 sdaReleased,
  output logic                 lastPulse,
  output logic                 done,
  output logic                 success,
  output logic                 fault
);

  localparam int CNT_W   = ((DIV_W > STRETCH_W) ? DIV_W : STRETCH_W) + 1;
  localparam int PULSE_W = $clog2(MAX_PULSES + 1);

  logic [DIV_W-1:0]       heff;
  logic [CNT_W-1:0]       phaseCnt, heffW, midW, limitW;
  logic [PULSE_W-1:0]     pulseCnt;
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sdaHigh;

  // Effective half-period, with a floor so the mid-high sample follows the synchronizer.
  assign heff   = (halfPeriod < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : halfPeriod;
  assign heffW  = CNT_W'(heff);
  assign midW   = heffW >> 1;
  assign limitW = CNT_W'(stretchLimit);

  // Line synchronizers; the parameter picks a single flop or a shift chain.
  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '0;
          sdaPipe <= '0;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '0;
          sdaPipe <= '0;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end
  endgenerate

  assign sclSeen = sclPipe[SYNC_STAGES-1];

  // Shared phase / stretch counter, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strobe.clearCnt) phaseCnt <= '0;
    else if (!(&phaseCnt))    phaseCnt <= phaseCnt + CNT_W'(1);
  end

  assign phaseEnd    = (phaseCnt == heffW - CNT_W'(1));
  assign pastMid     = (phaseCnt >= midW);
  assign stretchOver = (phaseCnt >= limitW);

  // SDA sample taken in the middle of the SCL-high phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   sdaHigh <= 1'b0;
    else if (strobe.pulseClear)                  sdaHigh <= 1'b0;
    else if (strobe.sampleEn && phaseCnt == midW) sdaHigh <= sdaPipe[SYNC_STAGES-1];
  end

  assign sdaReleased = sdaHigh;

  // Pulse counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseCnt <= '0;
    else if (strobe.pulseClear) pulseCnt <= '0;
    else if (strobe.pulseInc)   pulseCnt <= pulseCnt + PULSE_W'(1);
  end

  assign lastPulse = (pulseCnt == PULSE_W'(MAX_PULSES - 1));

  // Result registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      success <= 1'b0;
      fault   <= 1'b0;
    end else begin
      done <= strobe.finishOk | strobe.finishFault;
      if (strobe.resultClear) begin
        success <= 1'b0;
        fault   <= 1'b0;
      end else begin
        if (strobe.finishOk)    success <= 1'b1;
        if (strobe.finishFault) fault   <= 1'b1;
      end
    end
  end

  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_W'(MAX_PULSES));

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(success && fault));

endmodule

// File: rtl/unstick_ctrl.sv
module unstick_ctrl
  import unstick_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        phaseEnd,
  input  logic        pastMid,
  input  logic        sclSeen,
  input  logic        stretchOver,
  input  logic        sdaReleased,
  input  logic        lastPulse,
  output ctrlStrobe_t strobe,
  output logic        sclDriveLow,
  output logic        sdaDriveLow
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          nextState          = ST_LOW;
          strobe.pulseClear  = 1'b1;
          strobe.resultClear = 1'b1;
        end
      end
      ST_LOW: begin
        if (phaseEnd) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (sclSeen) nextState = ST_HIGH;
        else if (stretchOver) begin
          nextState          = ST_IDLE;
          strobe.finishFault = 1'b1;
        end
      end
      ST_HIGH: begin
        strobe.sampleEn = 1'b1;
        if (phaseEnd) begin
          strobe.pulseInc = 1'b1;
          if (sdaReleased) nextState = ST_STOP_LOW;
          else if (lastPulse) begin
            nextState          = ST_IDLE;
            strobe.finishFault = 1'b1;
          end else nextState = ST_LOW;
        end
      end
      ST_STOP_LOW: begin
        if (phaseEnd) nextState = ST_STOP_WAIT;
      end
      ST_STOP_WAIT: begin
        if (sclSeen) nextState = ST_STOP_HIGH;
        else if (stretchOver) begin
          nextState          = ST_IDLE;
          strobe.finishFault = 1'b1;
        end
      end
      ST_STOP_HIGH: begin
        if (phaseEnd) begin
          nextState       = ST_IDLE;
          strobe.finishOk = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.clearCnt = (nextState != state);
  end

  assign sclDriveLow = (state == ST_LOW) || (state == ST_STOP_LOW);
  assign sdaDriveLow = ((state == ST_STOP_LOW) && pastMid) ||
                       (state == ST_STOP_WAIT) || (state == ST_STOP_HIGH);

  assert_no_start_cond_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> sclDriveLow);

  assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> !sclDriveLow);

  assert_scl_fall_sda_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> !sdaDriveLow);

endmodule

// File: rtl/bus_unstick.sv
module bus_unstick
  import unstick_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int STRETCH_W   = 8,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HALF    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [DIV_W-1:0]     halfPeriod,
  input  logic [STRETCH_W-1:0] stretchLimit,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclDriveLow,
  output logic                 sdaDriveLow,
  output logic                 done,
  output logic                 success,
  output logic                 fault
);

  ctrlStrobe_t strobe;
  logic phaseEnd, pastMid, sclSeen, stretchOver, sdaReleased, lastPulse;

  unstick_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .phaseEnd    (phaseEnd),
    .pastMid     (pastMid),
    .sclSeen     (sclSeen),
    .stretchOver (stretchOver),
    .sdaReleased (sdaReleased),
    .lastPulse   (lastPulse),
    .strobe      (strobe),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow)
  );

  unstick_datapath #(
    .DIV_W       (DIV_W),
    .STRETCH_W   (STRETCH_W),
    .MAX_PULSES  (MAX_PULSES),
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_HALF    (MIN_HALF)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .halfPeriod   (halfPeriod),
    .stretchLimit (stretchLimit),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .phaseEnd     (phaseEnd),
    .pastMid      (pastMid),
    .sclSeen      (sclSeen),
    .stretchOver  (stretchOver),
    .sdaReleased  (sdaReleased),
    .lastPulse    (lastPulse),
    .done         (done),
    .success      (success),
    .fault        (fault)
  );

endmodule

// File: tb/tb_bus_unstick.sv
module tb_bus_unstick;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] halfPeriod = 8'd4;
  logic [7:0] stretchLimit = 8'd20;
  logic       sclLine, sdaLine;
  logic       sclDriveLow, sdaDriveLow, done, success, fault;

  int  compared = 0, mismatched = 0, cycles = 0;
  int  riseCnt, relIdx, holdCnt, lowRun, doneCnt, relAt, stretchAt, stretchLen, heffExp, snapRise;
  bit  prevDrv, prevSda, prevLine, tgtFree, widthBad, startBad, stopOk, monOn, doneSeen;
  bit  snapScl, snapSda;

  always #10 clk = ~clk;

  assign sclLine = !sclDriveLow && (holdCnt == 0);
  assign sdaLine = !sdaDriveLow && tgtFree;

  bus_unstick dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .halfPeriod(halfPeriod),
    .stretchLimit(stretchLimit), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .done(done), .success(success), .fault(fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bus model: a stuck target and an optional clock stretcher, updated away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (monOn) begin
      bit lineNow;
      if (prevDrv && !sclDriveLow) begin
        relIdx++;
        if (relIdx == stretchAt) holdCnt = stretchLen;
      end else if (holdCnt > 0) holdCnt--;
      lineNow = !sclDriveLow && (holdCnt == 0);
      if (lineNow && !prevLine && !sdaDriveLow) begin
        riseCnt++;
        if (riseCnt >= relAt) tgtFree = 1'b1;
      end
      if (sclDriveLow) lowRun++;
      else if (prevDrv) begin
        if (lowRun != heffExp) widthBad = 1'b1;
        lowRun = 0;
      end
      if (sdaDriveLow && !prevSda && lineNow) startBad = 1'b1;
      if (!sdaDriveLow && prevSda && lineNow) stopOk = 1'b1;
      if (done) begin
        doneCnt++;
        if (!doneSeen) begin
          doneSeen = 1'b1;
          snapRise = riseCnt;
          snapScl  = sclDriveLow;
          snapSda  = sdaDriveLow;
        end
      end
      prevDrv  = sclDriveLow;
      prevSda  = sdaDriveLow;
      prevLine = lineNow;
    end
  end

  task automatic runOne(input int h, input int k, input int sAt, input int sLen, input int lim,
                        input int againAt, input bit expOk, input int expPulses);
    int waited;
    monOn = 1'b0;
    @(negedge clk);
    halfPeriod   = 8'(h);
    stretchLimit = 8'(lim);
    heffExp  = (h < 4) ? 4 : h;
    relAt    = k;
    tgtFree  = (k == 0);
    stretchAt = sAt; stretchLen = sLen;
    riseCnt = 0; relIdx = 0; holdCnt = 0; lowRun = 0; doneCnt = 0; snapRise = 0;
    prevDrv = 1'b0; prevSda = 1'b0; prevLine = 1'b1;
    widthBad = 1'b0; startBad = 1'b0; stopOk = 1'b0; doneSeen = 1'b0;
    monOn = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waited = 0;
    while (!doneSeen && waited < 4000) begin
      @(negedge clk);
      waited++;
      startReq = (againAt != 0 && waited == againAt);
    end
    startReq = 1'b0;
    repeat (6) @(negedge clk);
    // R8: one done, exclusive and held result
    check(doneCnt == 1, "R8 done pulse count", doneCnt, 1);
    check(success == expOk, expOk ? "R5 success held" : "R6 success held low", int'(success), int'(expOk));
    check(fault == !expOk, expOk ? "R4 fault low" : "R6 R7 fault held", int'(fault), int'(!expOk));
    // R4 / R6: pulses issued before the closing phase
    check(snapRise == expPulses, "R4 pulse count", snapRise, expPulses);
    // R3: every SCL low interval has the effective half-period
    check(!widthBad, "R3 low phase width", int'(widthBad), 0);
    // R5 / R2: no SDA fall while SCL high; STOP edge only on success
    check(!startBad, "R2 SDA pulled low with SCL high", int'(startBad), 0);
    check(stopOk == expOk, "R5 STOP edge", int'(stopOk), int'(expOk));
    // R6: lines released at completion
    check(!snapScl && !snapSda, "R6 lines released at done", int'({snapScl, snapSda}), 0);
  endtask

  initial begin
    monOn = 1'b0; holdCnt = 0; tgtFree = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!sclDriveLow && !sdaDriveLow, "R1 drives idle in reset", int'({sclDriveLow, sdaDriveLow}), 0);
    check(!done && !success && !fault, "R1 results idle in reset", int'({done, success, fault}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!sclDriveLow && !sdaDriveLow && !done, "R1 idle after reset", int'({sclDriveLow, sdaDriveLow, done}), 0);

    // R3 R4 R5 R6: sweep release pulse against half-periods (including a clamped value)
    foreach (halfList[i]) begin
      for (int k = 0; k <= 10; k++) begin
        bit ok;
        int pulses;
        ok = (k <= 9);
        pulses = (k == 0) ? 1 : ((k > 9) ? 9 : k);
        runOne(halfList[i], k, 0, 0, 40, 0, ok, pulses);
      end
    end

    // R7: short stretch tolerated, long stretch aborts
    runOne(5, 5, 2, 10, 20, 0, 1'b1, 5);
    runOne(5, 5, 2, 30, 20, 0, 1'b0, 1);
    runOne(4, 9, 1, 60, 40, 0, 1'b0, 0);

    // R9: start while busy is ignored
    runOne(5, 3, 0, 0, 40, 20, 1'b1, 3);
    runOne(6, 12, 0, 0, 40, 50, 1'b0, 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  int halfList[4] = '{1, 4, 5, 9};

  initial begin
    while (cycles < 150000) @(negedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule